// File: doc/BRIEF.md
# Show-Ahead FIFO Adapter

This block is a single-clock FIFO whose output works in first-word-fall-through fashion. Inside it sits a plain FIFO core with inferred storage and a registered read port: a word requested from the core shows up one clock later. A small control layer around that core fetches the oldest word ahead of time. The consumer therefore sees that word on `rdData` whenever `empty` is low, and a read pulse takes it in the same cycle. The data path is unchanged apart from the prefetch. All the extra logic is flag and strobe control.

The parameter `EXTRA_REG` selects between two variants. With it at 0, the output word is the core's read register and a write into an empty FIFO becomes visible two cycles later. With it at 1, an extra flip-flop stage drives `rdData` and the latency grows to three cycles. The `clear` input is synchronous and empties the core and every prefetch stage at once. Programmable thresholds drive `nearlyEmpty` and `nearlyFull`, and `used` reports the total word count.

Top module: `showahead_fifo`

## Requirements
- R1: While `empty` is low, `rdData` holds the oldest unread word. A cycle with `rdEn` high removes that word, and the words leave in the order they were written. With `rdEn` low and `empty` low, `rdData` and `empty` do not change in the next cycle.
- R2: With `EXTRA_REG`=0, a word written into a completely empty FIFO in cycle t gives `empty` high in cycle t+1 and low in cycle t+2, with that word on `rdData`.
- R3: With `EXTRA_REG`=1, `rdData` comes straight from an output flip-flop. The same write gives `empty` high in cycles t+1 and t+2 and low in cycle t+3.
- R4: A write while `full` is high is dropped. The stored contents and `used` are the same as if `wrEn` had been low.
- R5: A read while `empty` is high is dropped. No word is lost and `used` does not fall.
- R6: `nearlyEmpty` is high exactly when `used` is at or below `NEAR_EMPTY_LVL`, which defaults to 1.
- R7: `nearlyFull` is high exactly when `used` is at or above `NEAR_FULL_LVL`, which defaults to DEPTH-1.
- R8: `used` is the number of words in the core plus the valid prefetch and output stages: one stage when `EXTRA_REG`=0, two when it is 1. The maximum is DEPTH+1 or DEPTH+2. `used` changes by at most one per cycle.
- R9: `full` is high exactly when the core holds DEPTH words.
- R10: A cycle with `clear` high leaves, in the next cycle, `used`=0, `empty` high and `full` low, whatever was stored before.
- R11: The core is read whenever it holds a word and its first stage is empty or being drained. When writes and reads occur in every cycle of a primed FIFO, one word passes per cycle and `used` stays constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| clear | input | 1 | Synchronous clear of all contents |
| wrEn | input | 1 | Write request |
| wrData | input | DATA_W | Word to write |
| rdEn | input | 1 | Consume the word shown on rdData |
| rdData | output | DATA_W | Oldest word, valid while empty is low |
| full | output | 1 | Core storage holds DEPTH words |
| empty | output | 1 | No word on rdData |
| nearlyFull | output | 1 | used at or above NEAR_FULL_LVL |
| nearlyEmpty | output | 1 | used at or below NEAR_EMPTY_LVL |
| used | output | $clog2(DEPTH+3) | Total words held |

## Verification
The bound checker covers the rules that hold in every cycle. It checks that the shown word is held steady while it is not taken, that a write into a full FIFO or a read from an empty one leaves `used` unchanged, that `used` moves by at most one step, that `full` implies at least DEPTH words, and that clear empties the structure. The two- and three-cycle write-to-visible latencies, the data order through the prefetch stages, the threshold flags and the one-word-per-cycle streaming are shown only by the bench. It runs both variants in parallel against a cycle model of the prefetch rule, using directed fills, drains and latency probes plus random traffic.

// File: rtl/sa_fifo_pkg.sv
package sa_fifo_pkg;

  // Strobes issued by the control to the datapath each cycle
  typedef struct packed {
    logic clr;    // synchronous clear of pointers and count
    logic push;   // accepted write into core storage
    logic pull;   // core read: load the read register from storage
    logic shift;  // move read register into output flop (extra stage only)
  } ctrlStrobes_t;

endpackage

// File: rtl/sa_fifo_datapath.sv
module sa_fifo_datapath
  import sa_fifo_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 8,
  parameter bit EXTRA_REG = 1'b0,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  ctrlStrobes_t      strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] qOut,
  output logic [CW-1:0]     innerCount
);

  logic [DATA_W-1:0] storage [DEPTH];
  logic [AW-1:0]     wrPtr;
  logic [AW-1:0]     rdPtr;
  logic [DATA_W-1:0] ramQ;

  // Pointer wrap helper for power-of-two and other depths
  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    if (int'(p) == DEPTH - 1) return '0;
    return p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strobe.push) storage[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (strobe.clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= nextPtr(wrPtr);
      if (strobe.pull) rdPtr <= nextPtr(rdPtr);
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.clr) innerCount <= '0;
    else begin
      case ({strobe.push, strobe.pull})
        2'b10:   innerCount <= innerCount + 1'b1;
        2'b01:   innerCount <= innerCount - 1'b1;
        default: innerCount <= innerCount;
      endcase
    end
  end

  // Registered read port: data appears the cycle after the pull strobe
  always_ff @(posedge clk) begin
    if (strobe.pull) ramQ <= storage[rdPtr];
  end

  generate
    if (EXTRA_REG) begin : gOutFlop
      logic [DATA_W-1:0] outReg;
      always_ff @(posedge clk) begin
        if (strobe.shift) outReg <= ramQ;
      end
      assign qOut = outReg;
    end else begin : gDirect
      assign qOut = ramQ;
    end
  endgenerate

endmodule

// File: rtl/sa_fifo_ctrl.sv
module sa_fifo_ctrl
  import sa_fifo_pkg::*;
#(
  parameter int DEPTH          = 8,
  parameter bit EXTRA_REG      = 1'b0,
  parameter int NEAR_EMPTY_LVL = 1,
  parameter int NEAR_FULL_LVL  = DEPTH - 1,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int UW = $clog2(DEPTH + 3)
) (
  input  logic          clk,
  input  logic          clear,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [CW-1:0] innerCount,
  output ctrlStrobes_t  strobe,
  output logic          empty,
  output logic          full,
  output logic          nearlyEmpty,
  output logic          nearlyFull,
  output logic [UW-1:0] used
);

  logic innerEmpty;
  logic innerFull;
  logic stage0Valid;   // read register holds a fetched word
  logic stage1Valid;   // output flop holds a word (extra stage only)
  logic outValid;
  logic consume;
  logic move;
  logic pull;
  logic drain0;

  assign innerEmpty = (innerCount == '0);
  assign innerFull  = (int'(innerCount) == DEPTH);

  generate
    if (EXTRA_REG) begin : gTwoStage
      assign outValid = stage1Valid;
      assign consume  = rdEn & stage1Valid;
      assign move     = stage0Valid & (~stage1Valid | consume);
      assign drain0   = move;

      always_ff @(posedge clk) begin
        if (clear)        stage1Valid <= 1'b0;
        else if (move)    stage1Valid <= 1'b1;
        else if (consume) stage1Valid <= 1'b0;
      end
    end else begin : gOneStage
      assign outValid    = stage0Valid;
      assign consume     = rdEn & stage0Valid;
      assign move        = 1'b0;
      assign drain0      = consume;
      assign stage1Valid = 1'b0;
    end
  endgenerate

  // Fetch from the core when it has data and stage 0 is free or leaving
  assign pull = ~innerEmpty & (~stage0Valid | drain0);

  always_ff @(posedge clk) begin
    if (clear)       stage0Valid <= 1'b0;
    else if (pull)   stage0Valid <= 1'b1;
    else if (drain0) stage0Valid <= 1'b0;
  end

  always_comb begin
    strobe       = '0;
    strobe.clr   = clear;
    strobe.push  = wrEn & ~innerFull & ~clear;
    strobe.pull  = pull & ~clear;
    strobe.shift = move & ~clear;
  end

  assign used        = UW'(innerCount) + UW'(stage0Valid) + UW'(stage1Valid);
  assign empty       = ~outValid;
  assign full        = innerFull;
  assign nearlyEmpty = (int'(used) <= NEAR_EMPTY_LVL);
  assign nearlyFull  = (int'(used) >= NEAR_FULL_LVL);

endmodule

// File: rtl/showahead_fifo.sv
module showahead_fifo
  import sa_fifo_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int DEPTH          = 8,
  parameter bit EXTRA_REG      = 1'b0,
  parameter int NEAR_EMPTY_LVL = 1,
  parameter int NEAR_FULL_LVL  = DEPTH - 1,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int UW = $clog2(DEPTH + 3)
) (
  input  logic              clk,
  input  logic              clear,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              full,
  output logic              empty,
  output logic              nearlyFull,
  output logic              nearlyEmpty,
  output logic [UW-1:0]     used
);

  ctrlStrobes_t  strobe;
  logic [CW-1:0] innerCount;

  sa_fifo_ctrl #(
    .DEPTH(DEPTH), .EXTRA_REG(EXTRA_REG),
    .NEAR_EMPTY_LVL(NEAR_EMPTY_LVL), .NEAR_FULL_LVL(NEAR_FULL_LVL)
  ) uCtrl (
    .clk(clk), .clear(clear), .wrEn(wrEn), .rdEn(rdEn),
    .innerCount(innerCount), .strobe(strobe),
    .empty(empty), .full(full), .nearlyEmpty(nearlyEmpty),
    .nearlyFull(nearlyFull), .used(used)
  );

  sa_fifo_datapath #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .EXTRA_REG(EXTRA_REG)
  ) uData (
    .clk(clk), .strobe(strobe), .wrData(wrData),
    .qOut(rdData), .innerCount(innerCount)
  );

endmodule

// File: rtl/sa_fifo_checker.sv
module sa_fifo_checker #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int UW = $clog2(DEPTH + 3)
) (
  input logic              clk,
  input logic              clear,
  input logic              wrEn,
  input logic              rdEn,
  input logic [DATA_W-1:0] rdData,
  input logic              full,
  input logic              empty,
  input logic [UW-1:0]     used
);

  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  assert_hold_head_R1: assert property (@(posedge clk) disable iff (clear)
    (!empty && !rdEn) |=> (!empty && $stable(rdData)));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (clear)
    (full && !(rdEn && !empty)) |=> (used == $past(used)));

  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (clear)
    (empty && !wrEn) |=> (used == $past(used)));

  assert_used_step_R8: assert property (@(posedge clk) disable iff (clear)
    !clear |=> ((int'(used) <= int'($past(used)) + 1) && (int'($past(used)) <= int'(used) + 1)));

  assert_full_count_R9: assert property (@(posedge clk) disable iff (clear)
    full |-> (int'(used) >= DEPTH));

  assert_clear_empties_R10: assert property (@(posedge clk)
    (started && $past(clear)) |-> (used == '0 && empty && !full));

endmodule

bind showahead_fifo sa_fifo_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uChk (
  .clk(clk), .clear(clear), .wrEn(wrEn), .rdEn(rdEn), .rdData(rdData),
  .full(full), .empty(empty), .used(used)
);

// File: tb/tb_showahead_fifo.sv
`timescale 1ns/1ps
module tb_showahead_fifo;

  localparam int DW = 8;
  localparam int D  = 8;
  localparam int UW = $clog2(D + 3);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic clear = 1'b1, wrEn = 1'b0, rdEn = 1'b0;
  logic [DW-1:0] wrData = '0;

  logic [DW-1:0] q0, q1;
  logic full0, full1, empty0, empty1, nf0, nf1, ne0, ne1;
  logic [UW-1:0] used0, used1;

  showahead_fifo #(.DATA_W(DW), .DEPTH(D), .EXTRA_REG(1'b0)) dut (
    .clk(clk), .clear(clear), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(q0), .full(full0), .empty(empty0), .nearlyFull(nf0),
    .nearlyEmpty(ne0), .used(used0));

  showahead_fifo #(.DATA_W(DW), .DEPTH(D), .EXTRA_REG(1'b1),
                   .NEAR_EMPTY_LVL(3), .NEAR_FULL_LVL(6)) dut2 (
    .clk(clk), .clear(clear), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(q1), .full(full1), .empty(empty1), .nearlyFull(nf1),
    .nearlyEmpty(ne1), .used(used1));

  int nCmp = 0, nBad = 0;

  // Model state, index 0 = one stage, 1 = two stages
  int mem [2][D];
  int head [2], cnt [2], v0 [2], v1 [2], d0 [2], d1 [2];
  int neLvl [2] = '{1, 3};
  int nfLvl [2] = '{D - 1, 6};

  task automatic cmp(string tag, int act, int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int expUsed(int m);
    return cnt[m] + v0[m] + v1[m];
  endfunction

  task automatic modelStep(int m);
    int consume, move, pull, wrOk;
    if (clear) begin
      head[m] = 0; cnt[m] = 0; v0[m] = 0; v1[m] = 0;
      return;
    end
    wrOk = (wrEn && cnt[m] < D) ? 1 : 0;
    if (m == 0) begin
      consume = (rdEn && v0[m] != 0) ? 1 : 0;
      move = 0;
      pull = (cnt[m] > 0 && (v0[m] == 0 || consume != 0)) ? 1 : 0;
    end else begin
      consume = (rdEn && v1[m] != 0) ? 1 : 0;
      move = (v0[m] != 0 && (v1[m] == 0 || consume != 0)) ? 1 : 0;
      pull = (cnt[m] > 0 && (v0[m] == 0 || move != 0)) ? 1 : 0;
      if (move != 0) begin d1[m] = d0[m]; v1[m] = 1; end
      else if (consume != 0) v1[m] = 0;
    end
    if (pull != 0) begin
      d0[m] = mem[m][head[m]];
      head[m] = (head[m] + 1) % D;
      cnt[m]--;
      v0[m] = 1;
    end else if ((m == 0 ? consume : move) != 0) v0[m] = 0;
    if (wrOk != 0) begin
      mem[m][(head[m] + cnt[m]) % D] = int'(wrData);
      cnt[m]++;
    end
  endtask

  task automatic checkAll();
    int e0, e1;
    e0 = (v0[0] == 0) ? 1 : 0;
    e1 = (v1[1] == 0) ? 1 : 0;
    cmp("R1 empty m0", int'(empty0), e0);
    cmp("R1 empty m1", int'(empty1), e1);
    if (e0 == 0) cmp("R1 head m0", int'(q0), d0[0]);
    if (e1 == 0) cmp("R1 head m1", int'(q1), d1[1]);
    cmp("R8 used m0", int'(used0), expUsed(0));
    cmp("R8 used m1", int'(used1), expUsed(1));
    cmp("R9 full m0", int'(full0), (cnt[0] == D) ? 1 : 0);
    cmp("R9 full m1", int'(full1), (cnt[1] == D) ? 1 : 0);
    cmp("R6 nearlyEmpty m0", int'(ne0), (expUsed(0) <= neLvl[0]) ? 1 : 0);
    cmp("R6 nearlyEmpty m1", int'(ne1), (expUsed(1) <= neLvl[1]) ? 1 : 0);
    cmp("R7 nearlyFull m0", int'(nf0), (expUsed(0) >= nfLvl[0]) ? 1 : 0);
    cmp("R7 nearlyFull m1", int'(nf1), (expUsed(1) >= nfLvl[1]) ? 1 : 0);
  endtask

  // Called at a falling edge; returns at the next falling edge, outputs checked
  task automatic step(logic c, logic w, int dv, logic r);
    clear = c; wrEn = w; wrData = DW'(dv); rdEn = r;
    @(posedge clk);
    modelStep(0);
    modelStep(1);
    @(negedge clk);
    checkAll();
  endtask

  bit timedOut = 1'b0;
  initial begin
    #(4 * 150000);
    timedOut = 1'b1;
    nCmp++; nBad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    int u0, u1;
    void'($urandom(32'd2024));
    for (int m = 0; m < 2; m++) begin
      head[m] = 0; cnt[m] = 0; v0[m] = 0; v1[m] = 0; d0[m] = 0; d1[m] = 0;
    end
    @(negedge clk);
    step(1'b1, 1'b0, 0, 1'b0);
    step(1'b1, 1'b0, 0, 1'b0);
    // Reset state (R10)
    cmp("R10 reset used m0", int'(used0), 0);
    cmp("R10 reset empty m1", int'(empty1), 1);

    // Latency probes (R2, R3)
    step(1'b0, 1'b1, 8'hA5, 1'b0);
    cmp("R2 empty t+1 m0", int'(empty0), 1);
    cmp("R3 empty t+1 m1", int'(empty1), 1);
    step(1'b0, 1'b0, 0, 1'b0);
    cmp("R2 empty t+2 m0", int'(empty0), 0);
    cmp("R2 data t+2 m0", int'(q0), 8'hA5);
    cmp("R3 empty t+2 m1", int'(empty1), 1);
    step(1'b0, 1'b0, 0, 1'b0);
    cmp("R3 empty t+3 m1", int'(empty1), 0);
    cmp("R3 data t+3 m1", int'(q1), 8'hA5);

    // Overfill: writes past capacity are dropped (R4, R9)
    step(1'b1, 1'b0, 0, 1'b0);
    for (int i = 0; i < D + 6; i++) step(1'b0, 1'b1, 16 + i, 1'b0);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 200, 1'b0);
    cmp("R4 used cap m0", int'(used0), D + 1);
    cmp("R4 used cap m1", int'(used1), D + 2);
    cmp("R9 full m0", int'(full0), 1);
    // Drain fully, order checked by model (R1), then read on empty (R5)
    for (int i = 0; i < D + 4; i++) step(1'b0, 1'b0, 0, 1'b1);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 0, 1'b1);
    cmp("R5 used after empty reads m0", int'(used0), 0);
    cmp("R5 used after empty reads m1", int'(used1), 0);
    step(1'b0, 1'b1, 8'h3C, 1'b1);
    step(1'b0, 1'b0, 0, 1'b1);
    step(1'b0, 1'b0, 0, 1'b0);
    cmp("R5 word kept m1", int'(q1), 8'h3C);

    // Streaming: prime then write and read every cycle (R11)
    step(1'b1, 1'b0, 0, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 60 + i, 1'b0);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 0, 1'b0);
    u0 = int'(used0); u1 = int'(used1);
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 80 + i, 1'b1);
    cmp("R11 stream used m0", int'(used0), u0);
    cmp("R11 stream used m1", int'(used1), u1);

    // Clear with contents (R10)
    step(1'b1, 1'b1, 1, 1'b0);
    cmp("R10 clear used m0", int'(used0), 0);
    cmp("R10 clear full m1", int'(full1), 0);

    // Random traffic with varied read/write biases
    for (int phase = 0; phase < 3; phase++) begin
      for (int i = 0; i < 1500; i++) begin
        int wp, rp;
        wp = (phase == 0) ? 70 : (phase == 1) ? 30 : 50;
        rp = (phase == 0) ? 30 : (phase == 1) ? 70 : 50;
        step(($urandom % 97) == 0, ($urandom % 100) < wp, int'($urandom % 256),
             ($urandom % 100) < rp);
      end
    end

    if (!timedOut) begin
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

endmodule